// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

This block turns one word written to a dispatch register into a control action for one CPU of a multi-CPU system. Each word holds a two-bit command, a five-bit target CPU number and a six-bit vector. The dispatcher can post an interrupt with that vector, run a power-on reset followed by a wake-up, stop a CPU so that interrupts do not wake it, or wake a CPU. Actions leave the block as single-cycle pulses on per-CPU reset, halt and resume lines, or as a one-cycle beat on an interrupt post channel that carries the CPU number and the vector.

Two kinds of word are rejected. A word whose target is not a present CPU has no effect; `cpu_count` tells the block how many CPUs exist. A reset word whose vector is not the power-on-reset code also has no effect, except that it sets a sticky error flag for software to read. Only a reset of the block clears that flag.

The sequencer has five states. `ST_IDLE` accepts a write. On an accepted word it moves to `ST_POST` (command 0), `ST_RESET` (command 1 with a matching vector), `ST_HALT` (command 2) or `ST_WAKE` (command 3). A rejected word keeps it in `ST_IDLE`. `ST_POST`, `ST_HALT` and `ST_WAKE` return to `ST_IDLE` after one cycle. `ST_RESET` always goes on to `ST_WAKE`. The block reports itself busy in every state except `ST_IDLE`, and writes made while it is busy are dropped.

Top module: `ipi_dispatch`

## Requirements
- R1: The command is taken from word bits 17:16, the target CPU from bits 12:8 and the vector from bits 5:0. All other bits are ignored.
- R2: An accepted command 0 sets `irq_valid` high for exactly the one cycle after the write edge, with `irq_cpu` and `irq_vec` equal to the word's target and vector.
- R3: An accepted command 1 whose vector equals `POR_VEC` (default 6'h01) raises the target's bit of `reset_pulse` for the first cycle after the write. It then raises the same bit of `resume_pulse` for the following cycle.
- R4: A command 1 with any other vector to a present CPU makes no pulse. It sets `err_flag` from the cycle after the write, and the flag stays set until reset.
- R5: An accepted command 2 raises the target's bit of `halt_pulse` for exactly one cycle after the write.
- R6: An accepted command 3 raises the target's bit of `resume_pulse` for exactly one cycle after the write.
- R7: A word whose target is at or above `cpu_count`, or at or above `MAX_CPUS`, has no effect: no pulse, no busy and no change of `err_flag`. This holds for every command, including a reset with a wrong vector.
- R8: `busy` is high in every cycle in which an action is being issued. A write made while `busy` is high is dropped.
- R9: After reset all pulse outputs, `irq_valid`, `busy` and `err_flag` are low.
- R10: In any cycle at most one output channel is active, and each per-CPU pulse vector has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Dispatch register write strobe |
| wr_data | input | DATA_W | Written command word |
| cpu_count | input | CNT_W | Number of present CPUs |
| irq_valid | output | 1 | Interrupt post beat |
| irq_cpu | output | 5 | Target CPU of the posted interrupt |
| irq_vec | output | 6 | Vector of the posted interrupt |
| reset_pulse | output | MAX_CPUS | Per-CPU power-on reset pulse |
| halt_pulse | output | MAX_CPUS | Per-CPU halt pulse |
| resume_pulse | output | MAX_CPUS | Per-CPU resume pulse |
| busy | output | 1 | Sequencer not idle; writes are dropped |
| err_flag | output | 1 | Sticky bad-reset-vector flag |

## Verification
A wrong state or a wrong latched target shows up on the ports in the first cycle after the write edge. The symptom is a pulse on the wrong channel or the wrong CPU bit, a missing pulse, or a stray pulse. A broken `ST_RESET` to `ST_WAKE` transition shows up one cycle later, as a missing or misplaced resume pulse. A wrong error flag shows up on `err_flag` in the cycle after a rejected reset word. A flag that clears early shows up at the next read, after the commands that follow it. A sequencer that accepts writes while busy puts an extra action onto the ports within two cycles of the dropped write.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int CMD_LSB = 16;
    localparam int CPU_LSB = 8;
    localparam int VEC_LSB = 0;
    localparam int CPU_W   = 5;
    localparam int VEC_W   = 6;

    typedef enum logic [1:0] {
        CMD_POST  = 2'd0,
        CMD_RESET = 2'd1,
        CMD_HALT  = 2'd2,
        CMD_WAKE  = 2'd3
    } ipi_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_POST  = 3'd1,
        ST_RESET = 3'd2,
        ST_WAKE  = 3'd3,
        ST_HALT  = 3'd4
    } ipi_state_e;

    typedef struct packed {
        ipi_cmd_e           kind;
        logic [CPU_W-1:0]   cpu;
        logic [VEC_W-1:0]   vec;
    } ipi_word_t;

endpackage

// File: rtl/ipi_field_decode.sv
module ipi_field_decode
    import ipi_pkg::*;
#(
    parameter int               DATA_W   = 32,
    parameter int               MAX_CPUS = 8,
    parameter logic [VEC_W-1:0] POR_VEC  = 6'h01,
    parameter int               CNT_W    = $clog2(MAX_CPUS + 1)
) (
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  cpu_count,
    output ipi_word_t         word,
    output logic              cpu_ok,
    output logic              vec_ok
);

    logic [1:0] cmd_bits;

    always_comb begin
        cmd_bits  = wr_data[CMD_LSB +: 2];
        word.kind = ipi_cmd_e'(cmd_bits);
        word.cpu  = wr_data[CPU_LSB +: CPU_W];
        word.vec  = wr_data[VEC_LSB +: VEC_W];
    end

    // A target must be below the live CPU count and inside the built array.
    always_comb begin
        cpu_ok = (32'(word.cpu) < 32'(cpu_count)) && (32'(word.cpu) < MAX_CPUS);
        vec_ok = (word.vec == POR_VEC);
    end

endmodule

// File: rtl/ipi_seq_fsm.sv
module ipi_seq_fsm
    import ipi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  ipi_word_t        word,
    input  logic             cpu_ok,
    input  logic             vec_ok,
    output ipi_state_e       state,
    output logic [CPU_W-1:0] cmd_cpu,
    output logic [VEC_W-1:0] cmd_vec,
    output logic             err_flag
);

    ipi_state_e       state_nx;
    logic             take;
    logic             bad_reset;
    logic             err_nx;
    logic [CPU_W-1:0] cpu_nx;
    logic [VEC_W-1:0] vec_nx;

    // A word is taken only while idle and only for a present CPU.
    always_comb begin
        take      = wr_valid && (state == ST_IDLE) && cpu_ok;
        bad_reset = take && (word.kind == CMD_RESET) && !vec_ok;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take) begin
                    unique case (word.kind)
                        CMD_POST:  state_nx = ST_POST;
                        CMD_RESET: state_nx = vec_ok ? ST_RESET : ST_IDLE;
                        CMD_HALT:  state_nx = ST_HALT;
                        CMD_WAKE:  state_nx = ST_WAKE;
                        default:   state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_POST:  state_nx = ST_IDLE;
            ST_RESET: state_nx = ST_WAKE;
            ST_WAKE:  state_nx = ST_IDLE;
            ST_HALT:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_nx = take ? word.cpu : cmd_cpu;
        vec_nx = take ? word.vec : cmd_vec;
        err_nx = err_flag | bad_reset;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cmd_cpu  <= '0;
            cmd_vec  <= '0;
            err_flag <= 1'b0;
        end else begin
            state    <= state_nx;
            cmd_cpu  <= cpu_nx;
            cmd_vec  <= vec_nx;
            err_flag <= err_nx;
        end
    end

endmodule

// File: rtl/ipi_pulse_drive.sv
module ipi_pulse_drive
    import ipi_pkg::*;
#(
    parameter int MAX_CPUS = 8
) (
    input  ipi_state_e       state,
    input  logic [CPU_W-1:0] cmd_cpu,
    input  logic [VEC_W-1:0] cmd_vec,
    output logic             irq_valid,
    output logic [CPU_W-1:0] irq_cpu,
    output logic [VEC_W-1:0] irq_vec,
    output logic [MAX_CPUS-1:0] reset_pulse,
    output logic [MAX_CPUS-1:0] halt_pulse,
    output logic [MAX_CPUS-1:0] resume_pulse,
    output logic             busy
);

    logic [MAX_CPUS-1:0] cpu_sel;
    logic                in_reset;
    logic                in_halt;
    logic                in_wake;

    for (genvar g = 0; g < MAX_CPUS; g++) begin : g_sel
        localparam logic [CPU_W-1:0] IDX = CPU_W'(g);
        assign cpu_sel[g] = (cmd_cpu == IDX);
    end

    always_comb begin
        irq_valid = 1'b0;
        in_reset  = 1'b0;
        in_halt   = 1'b0;
        in_wake   = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_IDLE:  busy      = 1'b0;
            ST_POST:  irq_valid = 1'b1;
            ST_RESET: in_reset  = 1'b1;
            ST_WAKE:  in_wake   = 1'b1;
            ST_HALT:  in_halt   = 1'b1;
            default:  busy      = 1'b0;
        endcase
        irq_cpu      = irq_valid ? cmd_cpu : '0;
        irq_vec      = irq_valid ? cmd_vec : '0;
        reset_pulse  = in_reset ? cpu_sel : '0;
        halt_pulse   = in_halt  ? cpu_sel : '0;
        resume_pulse = in_wake  ? cpu_sel : '0;
    end

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
    import ipi_pkg::*;
#(
    parameter int               DATA_W   = 32,
    parameter int               MAX_CPUS = 8,
    parameter logic [VEC_W-1:0] POR_VEC  = 6'h01,
    parameter int               CNT_W    = $clog2(MAX_CPUS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [CNT_W-1:0]    cpu_count,
    output logic                irq_valid,
    output logic [CPU_W-1:0]    irq_cpu,
    output logic [VEC_W-1:0]    irq_vec,
    output logic [MAX_CPUS-1:0] reset_pulse,
    output logic [MAX_CPUS-1:0] halt_pulse,
    output logic [MAX_CPUS-1:0] resume_pulse,
    output logic                busy,
    output logic                err_flag
);

    ipi_word_t        word;
    logic             cpu_ok;
    logic             vec_ok;
    ipi_state_e       state;
    logic [CPU_W-1:0] cmd_cpu;
    logic [VEC_W-1:0] cmd_vec;

    ipi_field_decode #(
        .DATA_W   (DATA_W),
        .MAX_CPUS (MAX_CPUS),
        .POR_VEC  (POR_VEC),
        .CNT_W    (CNT_W)
    ) u_decode (
        .wr_data   (wr_data),
        .cpu_count (cpu_count),
        .word      (word),
        .cpu_ok    (cpu_ok),
        .vec_ok    (vec_ok)
    );

    ipi_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .word     (word),
        .cpu_ok   (cpu_ok),
        .vec_ok   (vec_ok),
        .state    (state),
        .cmd_cpu  (cmd_cpu),
        .cmd_vec  (cmd_vec),
        .err_flag (err_flag)
    );

    ipi_pulse_drive #(
        .MAX_CPUS (MAX_CPUS)
    ) u_drive (
        .state        (state),
        .cmd_cpu      (cmd_cpu),
        .cmd_vec      (cmd_vec),
        .irq_valid    (irq_valid),
        .irq_cpu      (irq_cpu),
        .irq_vec      (irq_vec),
        .reset_pulse  (reset_pulse),
        .halt_pulse   (halt_pulse),
        .resume_pulse (resume_pulse),
        .busy         (busy)
    );

endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
    parameter int DATA_W   = 32,
    parameter int MAX_CPUS = 8,
    parameter int CNT_W    = $clog2(MAX_CPUS + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_valid,
    input logic [DATA_W-1:0]   wr_data,
    input logic [CNT_W-1:0]    cpu_count,
    input logic                irq_valid,
    input logic [MAX_CPUS-1:0] reset_pulse,
    input logic [MAX_CPUS-1:0] halt_pulse,
    input logic [MAX_CPUS-1:0] resume_pulse,
    input logic                busy,
    input logic                err_flag
);

    p_post_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    p_wake_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|reset_pulse) |=> (resume_pulse == $past(reset_pulse)));

    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_halt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|halt_pulse) |=> (halt_pulse == '0));

    p_wake_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|resume_pulse) |-> ($past(|reset_pulse) ||
                             $past(wr_valid && !busy && (wr_data[17:16] == 2'd3))));

    p_absent_cpu_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !busy && (32'(wr_data[12:8]) >= 32'(cpu_count)))
        |=> (!busy && $stable(err_flag)));

    p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid || (|reset_pulse) || (|halt_pulse) || (|resume_pulse)) |-> busy);

    p_one_channel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reset_pulse) && $onehot0(halt_pulse) && $onehot0(resume_pulse) &&
        ($countones({irq_valid, |reset_pulse, |halt_pulse, |resume_pulse}) <= 1));

endmodule

bind ipi_dispatch ipi_dispatch_chk #(
    .DATA_W   (DATA_W),
    .MAX_CPUS (MAX_CPUS),
    .CNT_W    (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_data      (wr_data),
    .cpu_count    (cpu_count),
    .irq_valid    (irq_valid),
    .reset_pulse  (reset_pulse),
    .halt_pulse   (halt_pulse),
    .resume_pulse (resume_pulse),
    .busy         (busy),
    .err_flag     (err_flag)
);

// File: tb/ipi_dispatch_test.sv
`timescale 1ns/1ps
module ipi_dispatch_test;

    localparam int DATA_W   = 32;
    localparam int MAX_CPUS = 8;
    localparam int CNT_W    = $clog2(MAX_CPUS + 1);

    typedef struct packed {
        logic [1:0] kind;   // 0 post, 1 reset, 2 halt, 3 resume
        logic [4:0] cpu;
        logic [5:0] vec;
    } item_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_valid = 1'b0;
    logic [DATA_W-1:0]   wr_data = '0;
    logic [CNT_W-1:0]    cpu_count = '0;
    logic                irq_valid;
    logic [4:0]          irq_cpu;
    logic [5:0]          irq_vec;
    logic [MAX_CPUS-1:0] reset_pulse;
    logic [MAX_CPUS-1:0] halt_pulse;
    logic [MAX_CPUS-1:0] resume_pulse;
    logic                busy;
    logic                err_flag;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    mon_on   = 1'b0;
    item_t exp_q[$];

    always #2 clk = ~clk;

    ipi_dispatch #(.DATA_W(DATA_W), .MAX_CPUS(MAX_CPUS)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .cpu_count(cpu_count), .irq_valid(irq_valid), .irq_cpu(irq_cpu),
        .irq_vec(irq_vec), .reset_pulse(reset_pulse), .halt_pulse(halt_pulse),
        .resume_pulse(resume_pulse), .busy(busy), .err_flag(err_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input int kind, input int cpu, input int vec);
        return (32'(kind) << 16) | (32'(cpu) << 8) | 32'(vec);
    endfunction

    // Expected actions for a word written while idle (R1..R7).
    task automatic expect_word(input logic [31:0] w);
        item_t it;
        int    cpu = int'(w[12:8]);
        if (cpu >= int'(cpu_count) || cpu >= MAX_CPUS) return;
        it.cpu = w[12:8];
        it.vec = 6'd0;
        case (w[17:16])
            2'd0: begin it.kind = 2'd0; it.vec = w[5:0]; exp_q.push_back(it); end
            2'd1: if (w[5:0] == 6'h01) begin
                      it.kind = 2'd1; exp_q.push_back(it);
                      it.kind = 2'd3; exp_q.push_back(it);
                  end
            2'd2: begin it.kind = 2'd2; exp_q.push_back(it); end
            default: begin it.kind = 2'd3; exp_q.push_back(it); end
        endcase
    endtask

    task automatic drive(input logic [31:0] w);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_data  = '0;
    endtask

    task automatic send(input logic [31:0] w);
        expect_word(w);
        drive(w);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare every observed action with the scoreboard queue.
    always @(negedge clk) begin
        if (mon_on) begin
            item_t got;
            got = '0;
            for (int k = 0; k < 4; k++) begin
                logic [MAX_CPUS-1:0] v;
                bit hit;
                hit = 1'b0;
                v = '0;
                if (k == 0) begin
                    hit = irq_valid;
                    got.cpu = irq_cpu;
                    got.vec = irq_vec;
                end else begin
                    v = (k == 1) ? reset_pulse : (k == 2) ? halt_pulse : resume_pulse;
                    hit = |v;
                    got.vec = 6'd0;
                    for (int i = 0; i < MAX_CPUS; i++) if (v[i]) got.cpu = 5'(i);
                end
                if (hit) begin
                    got.kind = 2'(k);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R10 unexpected action", int'(got), 0);
                    end else begin
                        item_t e;
                        e = exp_q.pop_front();
                        check(got == e, "R2/R3/R5/R6 action", int'(got), int'(e));
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: quiet after reset
        rst_n = 1'b1;
        @(negedge clk);
        check({irq_valid, reset_pulse, halt_pulse, resume_pulse, busy, err_flag} == '0,
              "R9 reset state", int'({busy, err_flag}), 0);
        cpu_count = CNT_W'(5);
        mon_on = 1'b1;

        // R1, R2: post with junk in the unused bits
        send(word(0, 3, 6'h2A) | 32'hFFFC_E0C0);
        check(irq_valid == 1'b1 && irq_cpu == 5'd3 && irq_vec == 6'h2A, "R2 post beat",
              int'({irq_cpu, irq_vec}), int'({5'd3, 6'h2A}));
        check(busy == 1'b1, "R8 busy while issuing", int'(busy), 1);
        settle();

        // R5 halt
        send(word(2, 4, 6'h00));
        check(halt_pulse == 8'h10, "R5 halt pulse", int'(halt_pulse), 'h10);
        settle();

        // R6 resume
        send(word(3, 0, 6'h11));
        check(resume_pulse == 8'h01, "R6 resume pulse", int'(resume_pulse), 1);
        settle();

        // R3 reset then wake, cycle by cycle
        send(word(1, 2, 6'h01));
        check(reset_pulse == 8'h04 && resume_pulse == '0, "R3 reset cycle",
              int'(reset_pulse), 4);
        @(negedge clk);
        check(resume_pulse == 8'h04 && reset_pulse == '0, "R3 wake cycle",
              int'(resume_pulse), 4);
        settle();

        // R7: absent targets, including a bad reset
        send(word(0, 5, 6'h05));
        check(busy == 1'b0 && irq_valid == 1'b0, "R7 absent cpu post", int'(busy), 0);
        settle();
        send(word(1, 7, 6'h09));
        check(busy == 1'b0 && err_flag == 1'b0, "R7 absent cpu bad reset",
              int'(err_flag), 0);
        settle();

        // R4: bad vector to a present CPU
        send(word(1, 1, 6'h02));
        check(err_flag == 1'b1 && busy == 1'b0 && reset_pulse == '0, "R4 bad vector",
              int'(err_flag), 1);
        settle();

        // R8: second write while busy is dropped
        send(word(1, 0, 6'h01));
        drive(word(2, 1, 6'h00));
        check(halt_pulse == '0, "R8 dropped write", int'(halt_pulse), 0);
        settle();

        // R3/R6 at the top CPU once more are present
        cpu_count = CNT_W'(8);
        send(word(3, 7, 6'h00));
        check(resume_pulse == 8'h80, "R6 top cpu resume", int'(resume_pulse), 'h80);
        settle();
        check(err_flag == 1'b1, "R4 flag still set", int'(err_flag), 1);
        check(exp_q.size() == 0, "R10 all expected actions seen", exp_q.size(), 0);

        // R9: reset clears the sticky flag
        mon_on = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(err_flag == 1'b0 && busy == 1'b0, "R9 flag cleared by reset",
              int'(err_flag), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule